// File: doc/BRIEF.md
# Wiper and Preset Register Command Engine

This block sits behind a byte-level serial slave front end and runs the command set of a digitally controlled potentiometer. It holds one volatile wiper register and a small bank of preset registers. The presets stand in for nonvolatile storage and are modelled as flip-flops. The front end reports each framing event to the engine: a start with the read/write bit after an address match, every byte that completes, and a stop. The engine decodes the instruction byte, collects or returns the 10-bit payload as two bytes, and performs transfers between the wiper and a preset.

A change to a preset is committed only when the stop arrives. It then holds `busy` high for a fixed number of clock cycles, which models the nonvolatile store time. While `busy` is high, the front end is expected to withhold its acknowledge, and the engine drops any new frame. The write-protect input blocks only preset updates. The wiper value drives a one-hot tap select for the resistor ladder. After reset the wiper is recalled from preset 0.

Top module: `wiper_preset_engine`

## Requirements
- R1: While `rst_n` is low, `busy` is high. Every preset takes its `PRESET_INIT` value (preset 0 defaults to 200h). On the first clock edge after reset is released, the wiper is loaded from preset 0 and `busy` falls.
- R2: A write frame (rw=0) whose instruction byte is 1010_0000 loads the wiper on the second data byte. The first data byte supplies value bits 9:8 in its bits 1:0, and its bits 7:2 are ignored. The second data byte supplies bits 7:0. `wp_n` has no effect on this write, and a frame with only one data byte leaves the wiper unchanged.
- R3: A read frame (rw=1) with instruction 1000_0000 (wiper) or 101_0_ss_00 (preset ss) sets `rd_byte` after the instruction byte to {6'b0, value[9:8]}. After one more byte it sets `rd_byte` to value[7:0].
- R4: A write frame with instruction 110_0_ss_00 followed by two data bytes (same layout as R2) changes preset ss only when the stop arrives.
- R5: Every accepted preset update raises `busy` on the clock edge that takes the stop. `busy` then stays high for exactly `STORE_CYC` cycles.
- R6: A read frame with instruction 110_0_ss_00 and no data bytes copies preset ss into the wiper at the stop, without raising `busy`.
- R7: A write frame with instruction 111_0_ss_00 and no data bytes copies the wiper into preset ss at the stop.
- R8: While `wp_n` is low at the stop, preset writes (R4) and wiper-to-preset copies (R7) change nothing and do not raise `busy`.
- R9: In each of these cases the preset write changes nothing and no store starts: the stop arrives before the second data byte, or a new start arrives before the stop.
- R10: An instruction byte is ignored, and no register changes and no store starts, in any of these cases: bit 4, 1 or 0 is set; the rw/opcode pair is not one of the six above; or a wiper command has a nonzero select field.
- R11: A start that arrives while `busy` is high is dropped, and so are the bytes and stop that follow it. This includes a start sampled on the last busy cycle.
- R12: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | One-cycle pulse: start condition with matched address |
| frm_rw | input | 1 | Read/write bit of the frame, valid with `frm_start` (1 = read) |
| byte_vld | input | 1 | One-cycle pulse: a byte has completed on the bus |
| byte_in | input | 8 | Received byte, valid with `byte_vld` |
| frm_stop | input | 1 | One-cycle pulse: stop condition |
| wp_n | input | 1 | Write protect, low blocks preset updates |
| rd_byte | output | 8 | Byte to be shifted out next on a read frame |
| busy | output | 1 | Recall or preset store in progress |
| wiper | output | VAL_W | Current wiper register |
| tap_sel | output | 2**VAL_W | One-hot tap select |

## Verification
The end of a preset store and the arrival of the next start can fall in the same clock cycle. The bench counts the cycles that follow the committing stop, then drives a start so that it is sampled exactly on the last cycle in which `busy` is still high. It judges the result by the outcome: the wiper write carried in that frame must leave the wiper untouched, and no new store may begin. A frame issued once `busy` has fallen is then accepted normally. Stops sampled with write protect low are also checked cycle by cycle, to confirm that `busy` never rises after them.

// File: rtl/wpe_pkg.sv
package wpe_pkg;

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_RD_W = 3'd1,
      K_WR_W = 3'd2,
      K_RD_P = 3'd3,
      K_WR_P = 3'd4,
      K_P2W  = 3'd5,
      K_W2P  = 3'd6
   } cmd_kind_e;

   typedef struct packed {
      cmd_kind_e  kind;
      logic [1:0] sel;
   } cmd_t;

   localparam int BYTE_W  = 8;
   localparam int SEL_LSB = 2;

endpackage

// File: rtl/wpe_cmd_decode.sv
module wpe_cmd_decode
   import wpe_pkg::*;
#(
   parameter int NUM_PRESETS = 4
) (
   input  logic              rw,
   input  logic [BYTE_W-1:0] instr,
   output cmd_t              cmd
);

   logic [2:0] op;
   logic [1:0] sel;
   logic       rsv;
   logic       sel_ok;

   always_comb begin
      op     = instr[7:5];
      sel    = instr[SEL_LSB +: 2];
      rsv    = instr[4] | instr[1] | instr[0];
      sel_ok = (32'(sel) < NUM_PRESETS);
      cmd.sel  = sel;
      cmd.kind = K_NONE;
      case ({rw, op})
         4'b1_100: if (sel == 2'd0) cmd.kind = K_RD_W;
         4'b1_101: if (sel_ok)      cmd.kind = K_RD_P;
         4'b1_110: if (sel_ok)      cmd.kind = K_P2W;
         4'b0_101: if (sel == 2'd0) cmd.kind = K_WR_W;
         4'b0_110: if (sel_ok)      cmd.kind = K_WR_P;
         4'b0_111: if (sel_ok)      cmd.kind = K_W2P;
         default:                   cmd.kind = K_NONE;
      endcase
      if (rsv) cmd.kind = K_NONE;
   end

endmodule

// File: rtl/wpe_store_timer.sv
module wpe_store_timer #(
   parameter int STORE_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);

   localparam int CNT_W = $clog2(STORE_CYC + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (go)
         cnt_q <= CNT_W'(STORE_CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/wpe_tap_decode.sv
module wpe_tap_decode #(
   parameter int VAL_W = 10
) (
   input  logic [VAL_W-1:0]      val,
   output logic [(1<<VAL_W)-1:0] tap_sel
);

   localparam int TAPS = 1 << VAL_W;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap_sel[t] = (val == VAL_W'(t));
   end

endmodule

// File: rtl/wiper_preset_engine.sv
module wiper_preset_engine
   import wpe_pkg::*;
#(
   parameter int VAL_W       = 10,
   parameter int NUM_PRESETS = 4,
   parameter int STORE_CYC   = 200,
   parameter logic [NUM_PRESETS*VAL_W-1:0] PRESET_INIT =
      {10'h3FF, 10'h0AA, 10'h155, 10'h200}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frm_start,
   input  logic                   frm_rw,
   input  logic                   byte_vld,
   input  logic [7:0]             byte_in,
   input  logic                   frm_stop,
   input  logic                   wp_n,
   output logic [7:0]             rd_byte,
   output logic                   busy,
   output logic [VAL_W-1:0]       wiper,
   output logic [(1<<VAL_W)-1:0]  tap_sel
);

   localparam int HI_W = VAL_W - BYTE_W;

   if (VAL_W < 9 || VAL_W > 16) begin : g_bad_width
      $error("VAL_W must lie in 9..16");
   end
   if (NUM_PRESETS < 1 || NUM_PRESETS > 4) begin : g_bad_presets
      $error("NUM_PRESETS must lie in 1..4");
   end
   if (STORE_CYC < 1) begin : g_bad_store
      $error("STORE_CYC must be at least 1");
   end

   // frame state
   logic             act_q;
   logic             rw_q;
   logic             have_cmd_q;
   cmd_t             cmd_q;
   logic [1:0]       dcnt_q;
   logic [HI_W-1:0]  hi_q;
   logic [VAL_W-1:0] pend_q;
   logic             pend_ok_q;
   logic [VAL_W-1:0] rd_q;
   logic             recall_q;
   logic [VAL_W-1:0] wiper_q;

   logic [VAL_W-1:0] preset_q [NUM_PRESETS];

   cmd_t             dec;
   logic             store_busy;
   logic             pre_we;
   logic [1:0]       pre_sel;
   logic [VAL_W-1:0] pre_wdata;
   logic             stop_ok;
   logic [VAL_W-1:0] wr_val;

   wpe_cmd_decode #(
      .NUM_PRESETS (NUM_PRESETS)
   ) dec_i (
      .rw    (rw_q),
      .instr (byte_in),
      .cmd   (dec)
   );

   assign busy    = store_busy | recall_q;
   assign stop_ok = frm_stop && !frm_start && act_q && have_cmd_q;
   assign wr_val  = {hi_q, byte_in};

   // preset update at stop, gated by write protect
   always_comb begin
      pre_sel   = cmd_q.sel;
      pre_wdata = pend_q;
      pre_we    = 1'b0;
      if (stop_ok && wp_n) begin
         if (cmd_q.kind == K_WR_P && pend_ok_q) begin
            pre_we = 1'b1;
         end else if (cmd_q.kind == K_W2P) begin
            pre_we    = 1'b1;
            pre_wdata = wiper_q;
         end
      end
   end

   for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_preset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            preset_q[g] <= PRESET_INIT[g*VAL_W +: VAL_W];
         else if (pre_we && pre_sel == 2'(g))
            preset_q[g] <= pre_wdata;
      end
   end

   wpe_store_timer #(
      .STORE_CYC (STORE_CYC)
   ) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (pre_we),
      .busy  (store_busy)
   );

   // frame sequencer and wiper register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         rw_q       <= 1'b0;
         have_cmd_q <= 1'b0;
         cmd_q      <= '{kind: K_NONE, sel: 2'd0};
         dcnt_q     <= 2'd0;
         hi_q       <= '0;
         pend_q     <= '0;
         pend_ok_q  <= 1'b0;
         rd_q       <= '0;
         recall_q   <= 1'b1;
         wiper_q    <= '0;
      end else begin
         if (recall_q) begin
            wiper_q  <= preset_q[0];
            recall_q <= 1'b0;
         end
         if (frm_start) begin
            act_q      <= !busy;
            rw_q       <= frm_rw;
            have_cmd_q <= 1'b0;
            dcnt_q     <= 2'd0;
            pend_ok_q  <= 1'b0;
         end else if (frm_stop) begin
            act_q     <= 1'b0;
            pend_ok_q <= 1'b0;
            if (stop_ok && cmd_q.kind == K_P2W)
               wiper_q <= preset_q[cmd_q.sel];
         end else if (byte_vld && act_q) begin
            if (!have_cmd_q) begin
               have_cmd_q <= 1'b1;
               cmd_q      <= dec;
               dcnt_q     <= 2'd0;
               if (dec.kind == K_NONE)
                  act_q <= 1'b0;
               rd_q <= (dec.kind == K_RD_P) ? preset_q[dec.sel] : wiper_q;
            end else begin
               if (dcnt_q != 2'd3)
                  dcnt_q <= dcnt_q + 2'd1;
               if (cmd_q.kind == K_WR_W || cmd_q.kind == K_WR_P) begin
                  if (dcnt_q == 2'd0) begin
                     hi_q <= byte_in[HI_W-1:0];
                  end else if (dcnt_q == 2'd1) begin
                     if (cmd_q.kind == K_WR_W) begin
                        wiper_q <= wr_val;
                     end else begin
                        pend_q    <= wr_val;
                        pend_ok_q <= 1'b1;
                     end
                  end
               end
            end
         end
      end
   end

   // read data presented to the front end
   always_comb begin
      rd_byte = 8'h00;
      if (act_q && have_cmd_q &&
          (cmd_q.kind == K_RD_W || cmd_q.kind == K_RD_P)) begin
         case (dcnt_q)
            2'd0:    rd_byte = 8'(rd_q >> BYTE_W);
            2'd1:    rd_byte = rd_q[7:0];
            default: rd_byte = 8'h00;
         endcase
      end
   end

   assign wiper = wiper_q;

   wpe_tap_decode #(
      .VAL_W (VAL_W)
   ) tap_i (
      .val     (wiper_q),
      .tap_sel (tap_sel)
   );

endmodule

// File: rtl/wpe_checker.sv
module wpe_checker #(
   parameter int VAL_W     = 10,
   parameter int STORE_CYC = 200
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  frm_stop,
   input logic                  byte_vld,
   input logic                  wp_n,
   input logic [VAL_W-1:0]      wiper,
   input logic [(1<<VAL_W)-1:0] tap_sel
);

   localparam int RUN_W = $clog2(STORE_CYC + 2) + 1;

   logic [RUN_W-1:0] run_q;
   logic             seen_idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= '0;
         seen_idle_q <= 1'b0;
      end else begin
         run_q       <= busy ? run_q + 1'b1 : '0;
         seen_idle_q <= seen_idle_q | !busy;
      end
   end

   // R12
   tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(tap_sel) && tap_sel[wiper]);

   // R5
   busy_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RUN_W'(STORE_CYC)));

   // R5
   busy_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && seen_idle_q) |-> (run_q == RUN_W'(STORE_CYC)));

   // R8
   wp_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_stop && !wp_n && !busy) |=> !busy);

   // R2
   wiper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && !frm_stop && !busy) |=> $stable(wiper));

endmodule

bind wiper_preset_engine wpe_checker #(
   .VAL_W     (VAL_W),
   .STORE_CYC (STORE_CYC)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .frm_stop (frm_stop),
   .byte_vld (byte_vld),
   .wp_n     (wp_n),
   .wiper    (wiper),
   .tap_sel  (tap_sel)
);

// File: tb/wiper_preset_engine_tb_top.sv
`timescale 1ns/1ps
module wiper_preset_engine_tb_top;

   localparam int S = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_start = 1'b0;
   logic        frm_rw = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic        frm_stop = 1'b0;
   logic        wp_n = 1'b1;
   logic [7:0]  rd_byte;
   logic        busy;
   logic [9:0]  wiper;
   logic [1023:0] tap_sel;

   int nchk = 0;
   int nfail = 0;

   logic [9:0] m_w;
   logic [9:0] m_p [4];

   always #2.5 clk = ~clk;

   wiper_preset_engine #(
      .VAL_W       (10),
      .NUM_PRESETS (4),
      .STORE_CYC   (S)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .frm_rw    (frm_rw),
      .byte_vld  (byte_vld),
      .byte_in   (byte_in),
      .frm_stop  (frm_stop),
      .wp_n      (wp_n),
      .rd_byte   (rd_byte),
      .busy      (busy),
      .wiper     (wiper),
      .tap_sel   (tap_sel)
   );

   task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // instruction builders
   function automatic logic [7:0] ins(input logic [2:0] op, input logic [1:0] sel);
      return {op, 1'b0, sel, 2'b00};
   endfunction

   function automatic bit instr_valid(input logic rw, input logic [7:0] b);
      logic [2:0] op;
      op = b[7:5];
      if (b[4] | b[1] | b[0]) return 0;
      if (rw) return (op == 3'b100 && b[3:2] == 2'd0) || op == 3'b101 || op == 3'b110;
      return (op == 3'b101 && b[3:2] == 2'd0) || op == 3'b110 || op == 3'b111;
   endfunction

   // all tasks enter and leave at a falling edge
   task automatic fstart(input logic rw);
      frm_start = 1'b1; frm_rw = rw;
      @(negedge clk);
      frm_start = 1'b0;
   endtask

   task automatic fbyte(input logic [7:0] b);
      byte_vld = 1'b1; byte_in = b;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic fstop();
      frm_stop = 1'b1;
      @(negedge clk);
      frm_stop = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < 10000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rd_frame(input logic [7:0] instr, output logic [9:0] v, output logic [7:0] hi);
      fstart(1'b1);
      fbyte(instr);
      hi = rd_byte;
      fbyte(8'h00);
      v = {hi[1:0], rd_byte};
      fstop();
   endtask

   task automatic wr_frame(input logic [7:0] instr, input logic [9:0] v, input logic [5:0] junk,
                           input int nbytes, output int n);
      fstart(1'b0);
      fbyte(instr);
      if (nbytes > 0) fbyte({junk, v[9:8]});
      if (nbytes > 1) fbyte(v[7:0]);
      fstop();
      busy_len(n);
   endtask

   task automatic check_state(input string tag);
      logic [9:0] v;
      logic [7:0] hi;
      chk({tag, " R12 wiper port"}, wiper, m_w);
      chk({tag, " R12 tap bit"}, tap_sel[m_w], 1);
      chk({tag, " R12 tap count"}, $countones(tap_sel), 1);
      rd_frame(8'h80, v, hi);
      chk({tag, " R3 wiper read"}, v, m_w);
      chk({tag, " R3 high byte pad"}, hi[7:2], 0);
      for (int s = 0; s < 4; s++) begin
         rd_frame(ins(3'b101, 2'(s)), v, hi);
         chk({tag, " R3 preset read"}, v, m_p[s]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int n;
      logic [9:0] v;
      logic [7:0] b;
      logic [1:0] sel;
      logic       rw;
      logic       wp;
      int unsigned kind;
      void'($urandom(32'h5eed_0c0d));

      m_p[0] = 10'h200; m_p[1] = 10'h155; m_p[2] = 10'h0AA; m_p[3] = 10'h3FF;

      // R1: reset and recall
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy, 1);
      rst_n = 1'b1;
      @(negedge clk);
      m_w = m_p[0];
      chk("R1 recall wiper", wiper, 10'h200);
      chk("R1 busy after recall", busy, 0);
      check_state("R1 init");

      // R2: wiper write under write protect, junk high bits, boundary values
      wp_n = 1'b0;
      wr_frame(8'hA0, 10'h3FF, 6'h2A, 2, n);
      m_w = 10'h3FF;
      chk("R2 no busy", n, 0);
      chk("R2 wiper 3FF", wiper, m_w);
      chk("R12 top tap", tap_sel[1023], 1);
      wr_frame(8'hA0, 10'h000, 6'h3F, 2, n);
      m_w = 10'h000;
      chk("R2 wiper 000", wiper, m_w);
      chk("R12 bottom tap", tap_sel[0], 1);
      wr_frame(8'hA0, 10'h123, 6'h00, 1, n);
      chk("R2 one data byte", wiper, m_w);

      // R8: write protect blocks preset write and wiper-to-preset copy
      wr_frame(ins(3'b110, 2'd1), 10'h2C3, 6'h0, 2, n);
      chk("R8 write blocked busy", n, 0);
      wr_frame(ins(3'b111, 2'd2), 10'h0, 6'h0, 0, n);
      chk("R8 copy blocked busy", n, 0);
      check_state("R8");
      wp_n = 1'b1;

      // R4/R5: preset write commits at stop with exact busy length
      wr_frame(ins(3'b110, 2'd1), 10'h2C3, 6'h15, 2, n);
      m_p[1] = 10'h2C3;
      chk("R5 busy cycles", n, S);
      check_state("R4");

      // R9: aborted preset writes
      wr_frame(ins(3'b110, 2'd2), 10'h111, 6'h0, 1, n);
      chk("R9 short write busy", n, 0);
      fstart(1'b0); fbyte(ins(3'b110, 2'd3)); fbyte(8'h01); fbyte(8'h22);
      fstart(1'b1); fbyte(8'h80); fstop();
      busy_len(n);
      chk("R9 restart busy", n, 0);
      check_state("R9");

      // R10: reserved bit, nonzero select on wiper command, unknown opcode
      wr_frame(8'hA1, 10'h155, 6'h0, 2, n);
      chk("R10 reserved bit busy", n, 0);
      wr_frame(8'hA4, 10'h155, 6'h0, 2, n);
      wr_frame(ins(3'b110, 2'd0) | 8'h10, 10'h155, 6'h0, 2, n);
      chk("R10 reserved bit4 busy", n, 0);
      fstart(1'b1); fbyte(ins(3'b111, 2'd0)); fstop();
      check_state("R10");

      // R6/R7: copies
      fstart(1'b1); fbyte(ins(3'b110, 2'd3)); fstop();
      m_w = m_p[3];
      busy_len(n);
      chk("R6 copy no busy", n, 0);
      chk("R6 wiper from preset", wiper, m_w);
      wr_frame(8'hA0, 10'h0F0, 6'h0, 2, n);
      m_w = 10'h0F0;

      // R11: start sampled on the last busy cycle is dropped
      fstart(1'b0); fbyte(ins(3'b111, 2'd0)); fstop();
      m_p[0] = m_w;
      repeat (S - 1) @(negedge clk);
      chk("R11 still busy", busy, 1);
      fstart(1'b0); fbyte(8'hA0); fbyte(8'h03); fbyte(8'h33); fstop();
      busy_len(n);
      chk("R11 no new store", n, 0);
      chk("R11 wiper kept", wiper, m_w);
      check_state("R7");

      // random mix
      for (int it = 0; it < 200; it++) begin
         kind = $urandom_range(0, 6);
         sel  = 2'($urandom_range(0, 3));
         v    = 10'($urandom);
         wp   = ($urandom_range(0, 3) != 0);
         wp_n = wp;
         case (kind)
            0: begin
               wr_frame(8'hA0, v, 6'($urandom), 2, n);
               m_w = v;
               chk("R2 random write", wiper, m_w);
            end
            1: begin
               wr_frame(ins(3'b110, sel), v, 6'($urandom), 2, n);
               if (wp) m_p[sel] = v;
               chk("R5 random busy", n, wp ? S : 0);
            end
            2: begin
               fstart(1'b1); fbyte(ins(3'b110, sel)); fstop();
               m_w = m_p[sel];
               chk("R6 random copy", wiper, m_w);
            end
            3: begin
               wr_frame(ins(3'b111, sel), 10'h0, 6'h0, 0, n);
               if (wp) m_p[sel] = m_w;
               chk("R7 random busy", n, wp ? S : 0);
            end
            4: begin
               rd_frame(8'h80, v, b);
               chk("R3 random wiper read", v, m_w);
            end
            5: begin
               rd_frame(ins(3'b101, sel), v, b);
               chk("R3 random preset read", v, m_p[sel]);
            end
            default: begin
               rw = 1'($urandom);
               b = 8'($urandom);
               while (instr_valid(rw, b)) b = 8'($urandom);
               fstart(rw); fbyte(b); fbyte(8'($urandom)); fbyte(8'($urandom)); fstop();
               busy_len(n);
               chk("R10 random invalid busy", n, 0);
               chk("R10 random invalid wiper", wiper, m_w);
            end
         endcase
         if (it % 20 == 19) check_state("random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule